// File: doc/BRIEF.md
# Double-to-Int32 Wrapping Truncation Converter

This unit takes a 64-bit binary floating-point value and turns it into a 32-bit two's-complement integer. It always truncates toward zero. When the value does not fit, the result is not clamped: the unit returns the low 32 bits of the truncated integer, so the result wraps modulo 2^32. Beside the integer it reports an exactness bit and three mutually exclusive exception flags: invalid, inexact and input-denormal. The exactness bit is high only when the integer is exact and in range. A negative zero input counts as inexact for the exactness bit.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream through one register stage. An accepted operand shows up at the output on the next clock edge. A result waits at the output until the consumer takes it. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure passes straight through with no extra buffering. The input-flush control is a plain level. It is sampled together with the operand it applies to.

Top module: `f2i_wrap_conv`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The operand word holds the sign in bit 63, the biased exponent (bias 1023) in bits 62:52 and the fraction in bits 51:0. A finite operand whose value is an integer in [-2^31, 2^31-1] gives that integer in two's complement, with out_exact=1 and no flag raised.
- R3: A finite nonzero operand with a fractional part and a truncated magnitude within range gives the value truncated toward zero, with out_inexact=1 and out_exact=0. Magnitudes far below 1 (down to exponent fields whose shift exceeds 64 places) give 0 and are inexact.
- R4: An operand whose truncated magnitude exceeds 2^31-1 (positive) or 2^31 (negative) raises out_invalid only, clears out_exact, and returns the low 32 bits of the signed truncated integer. This includes shifts of 64 places or more, which return 0.
- R5: An exponent field of all ones (infinity or NaN) returns 0 with out_invalid=1 and out_exact=0.
- R6: A positive zero returns 0 with out_exact=1 and no flag. A negative zero returns 0 with out_exact=0 and no flag.
- R7: A subnormal operand (exponent field 0, fraction nonzero) returns 0 with out_exact=0. It raises out_denorm when flush_den is high and out_inexact when flush_den is low. flush_den has no effect on other operands.
- R8: At most one of out_invalid, out_inexact and out_denorm is high. out_exact=1 implies all three are low.
- R9: An operand accepted on a clock edge appears at the output after exactly that edge. With no new operand, out_valid falls on the edge where the result is taken.
- R10: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_den | input | 1 | Treat subnormal operands as flushed (denormal flag instead of inexact) |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 64 | Floating-point operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Truncated integer, wrapped modulo 2^32 |
| out_exact | output | 1 | Conversion exact and in range |
| out_invalid | output | 1 | Out of range, infinity or NaN |
| out_inexact | output | 1 | Nonzero bits discarded (in-range result or unflushed subnormal) |
| out_denorm | output | 1 | Subnormal operand seen with flushing enabled |

## Verification
Exact integers at both edges of the signed range show whether the range limit depends on the sign correctly. Values that carry a fraction, including very small ones, show whether bits lost in the right-shift path are detected. Operands just past each limit, and operands far enough up that the left shift moves bits out of the low word or clears it entirely, show whether the wrapped result and the invalid flag come from the right shift direction. Zeros of both signs, subnormals under both flush settings, infinities and a NaN cover every special class. A back-pressure sequence shows that results are held, that ready is blocked, and that the held result is replaced in the same cycle it is taken.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // default format widths (binary64 in, 32-bit integer out)
  localparam int DEF_EXP_W  = 11;
  localparam int DEF_FRAC_W = 52;
  localparam int DEF_INT_W  = 32;

  // operand class after field decode
  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_INFNAN  = 2'd3
  } fp_class_e;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       mant_o,
  output fp_class_e             cls_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;

  assign sign_o    = word_i[W-1];
  assign exp_o     = word_i[W-2:FRAC_W];
  assign frac      = word_i[FRAC_W-1:0];
  assign exp_zero  = (exp_o == '0);
  assign exp_ones  = (exp_o == {EXP_W{1'b1}});
  assign frac_zero = (frac == '0);

  // hidden bit restored; only consumed for normal operands
  assign mant_o = {1'b1, frac};

  always_comb begin
    if (exp_ones)       cls_o = CLS_INFNAN;
    else if (!exp_zero) cls_o = CLS_NORMAL;
    else if (frac_zero) cls_o = CLS_ZERO;
    else                cls_o = CLS_SUBNORM;
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [FRAC_W:0]  mant_i,
  output logic [INT_W-1:0] mag_o,
  output logic             lost_o,
  output logic             over_o
);
  localparam int MW     = FRAC_W + 1;
  localparam int XW     = MW + INT_W;
  localparam int AW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int POINT  = BIAS + FRAC_W;
  localparam int OVER_E = BIAS + INT_W - 1;

  localparam logic [AW-1:0] POINT_X = AW'(POINT);
  localparam logic [AW-1:0] OVER_X  = AW'(OVER_E);

  logic [AW-1:0]    e_x;
  logic             go_left;
  logic [AW-1:0]    amt;
  logic [XW-1:0]    ext;
  logic [XW-1:0]    keep_mask;
  logic [INT_W-1:0] mag_left;
  logic [INT_W-1:0] mag_right;

  assign e_x     = {2'b00, exp_i};
  assign go_left = (e_x >= POINT_X);
  assign amt     = go_left ? (e_x - POINT_X) : (POINT_X - e_x);
  assign ext     = {{INT_W{1'b0}}, mant_i};

  // only the low integer word is ever needed: the wrapped result
  // depends on nothing above it, range is judged from the exponent
  assign mag_left  = INT_W'(ext << amt);
  assign mag_right = INT_W'(ext >> amt);

  // bits that fall below the binary point (all of them past the window)
  assign keep_mask = ~({XW{1'b1}} << amt);

  assign mag_o  = go_left ? mag_left : mag_right;
  assign lost_o = !go_left && (|(ext & keep_mask));
  assign over_o = (e_x > OVER_X);

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
#(
  parameter int INT_W = DEF_INT_W
) (
  input  logic             sign_i,
  input  fp_class_e        cls_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             over_i,
  input  logic             flush_i,
  output logic [INT_W-1:0] result_o,
  output logic             exact_o,
  output logic             invalid_o,
  output logic             inexact_o,
  output logic             denorm_o
);
  localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] lim;
  logic             out_of_range;
  logic [INT_W-1:0] signed_mag;

  assign lim          = sign_i ? NEG_LIM : POS_LIM;
  assign out_of_range = over_i || (mag_i > lim);
  assign signed_mag   = sign_i ? (~mag_i + 1'b1) : mag_i;

  always_comb begin
    result_o  = '0;
    exact_o   = 1'b0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    denorm_o  = 1'b0;
    unique case (cls_i)
      CLS_ZERO: begin
        // a negative zero is reported as not exact, without a flag
        exact_o = !sign_i;
      end
      CLS_SUBNORM: begin
        denorm_o  = flush_i;
        inexact_o = !flush_i;
      end
      CLS_INFNAN: begin
        invalid_o = 1'b1;
      end
      CLS_NORMAL: begin
        result_o  = signed_mag;
        invalid_o = out_of_range;
        inexact_o = !out_of_range && lost_i;
        exact_o   = !out_of_range && !lost_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/f2i_wrap_conv.sv
module f2i_wrap_conv
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_den,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result,
  output logic        out_exact,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_denorm
);
  localparam int EXP_W  = DEF_EXP_W;
  localparam int FRAC_W = DEF_FRAC_W;
  localparam int INT_W  = DEF_INT_W;

  logic              op_sign;
  logic [EXP_W-1:0]  op_exp;
  logic [FRAC_W:0]   op_mant;
  fp_class_e         op_cls;
  logic [INT_W-1:0]  al_mag;
  logic              al_lost;
  logic              al_over;
  logic [INT_W-1:0]  nx_result;
  logic              nx_exact;
  logic              nx_invalid;
  logic              nx_inexact;
  logic              nx_denorm;
  logic              take;

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .word_i (in_data),
    .sign_o (op_sign),
    .exp_o  (op_exp),
    .mant_o (op_mant),
    .cls_o  (op_cls)
  );

  f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .exp_i  (op_exp),
    .mant_i (op_mant),
    .mag_o  (al_mag),
    .lost_o (al_lost),
    .over_o (al_over)
  );

  f2i_pack #(.INT_W(INT_W)) u_pack (
    .sign_i    (op_sign),
    .cls_i     (op_cls),
    .mag_i     (al_mag),
    .lost_i    (al_lost),
    .over_i    (al_over),
    .flush_i   (flush_den),
    .result_o  (nx_result),
    .exact_o   (nx_exact),
    .invalid_o (nx_invalid),
    .inexact_o (nx_inexact),
    .denorm_o  (nx_denorm)
  );

  // single output stage: ready passes through when the slot drains
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result  <= '0;
      out_exact   <= 1'b0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else if (take) begin
      out_result  <= nx_result;
      out_exact   <= nx_exact;
      out_invalid <= nx_invalid;
      out_inexact <= nx_inexact;
      out_denorm  <= nx_denorm;
    end
  end

  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_invalid, out_inexact, out_denorm}));

  p_exact_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exact) |-> !(out_invalid || out_inexact || out_denorm));

  p_denorm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_denorm) |-> (out_result == '0 && !out_exact));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable({out_exact, out_invalid, out_inexact, out_denorm})));

  p_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/f2i_wrap_conv_test.sv
module f2i_wrap_conv_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_den = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_exact;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_denorm;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  f2i_wrap_conv uut (
    .clk(clk), .rst_n(rst_n), .flush_den(flush_den),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_exact(out_exact), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flags packed as {exact, invalid, inexact, denorm}
  task automatic send(string tag, logic [63:0] d, logic fl,
                      logic [31:0] res, logic [3:0] flags);
    @(negedge clk);
    in_data   = d;
    flush_den = fl;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " result"}, 64'(out_result), 64'(res));
    chk({tag, " flags"}, 64'({out_exact, out_invalid, out_inexact, out_denorm}),
        64'(flags));
    chk({tag, " R8 flag count"},
        64'(32'(out_invalid) + 32'(out_inexact) + 32'(out_denorm) > 1), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_exact;
    send("R2 1.0",        64'h3FF0000000000000, 1'b0, 32'h00000001, 4'b1000);
    send("R2 -1.0",       64'hBFF0000000000000, 1'b0, 32'hFFFFFFFF, 4'b1000);
    send("R2 2^31-1",     64'h41DFFFFFFFC00000, 1'b0, 32'h7FFFFFFF, 4'b1000);
    send("R2 -2^31",      64'hC1E0000000000000, 1'b0, 32'h80000000, 4'b1000);
  endtask

  task automatic t_trunc;
    send("R3 2.5",        64'h4004000000000000, 1'b0, 32'h00000002, 4'b0010);
    send("R3 -2.5",       64'hC004000000000000, 1'b0, 32'hFFFFFFFE, 4'b0010);
    send("R3 0.5",        64'h3FE0000000000000, 1'b0, 32'h00000000, 4'b0010);
    send("R3 -0.5",       64'hBFE0000000000000, 1'b0, 32'h00000000, 4'b0010);
    send("R3 2^-100",     64'h39B0000000000000, 1'b0, 32'h00000000, 4'b0010);
  endtask

  task automatic t_range;
    send("R4 2^31",       64'h41E0000000000000, 1'b0, 32'h80000000, 4'b0100);
    send("R4 -2^31-1",    64'hC1E0000000200000, 1'b0, 32'h7FFFFFFF, 4'b0100);
    send("R4 2^32+5",     64'h41F0000000500000, 1'b0, 32'h00000005, 4'b0100);
    send("R4 -(2^32+5)",  64'hC1F0000000500000, 1'b0, 32'hFFFFFFFB, 4'b0100);
    send("R4 left10",     64'h43D0000000000001, 1'b0, 32'h00000400, 4'b0100);
    send("R4 2^116",      64'h4730000000000000, 1'b0, 32'h00000000, 4'b0100);
  endtask

  task automatic t_special;
    send("R5 +inf",       64'h7FF0000000000000, 1'b0, 32'h00000000, 4'b0100);
    send("R5 -inf",       64'hFFF0000000000000, 1'b0, 32'h00000000, 4'b0100);
    send("R5 nan",        64'h7FF8000000000000, 1'b0, 32'h00000000, 4'b0100);
  endtask

  task automatic t_zero;
    send("R6 +0",         64'h0000000000000000, 1'b0, 32'h00000000, 4'b1000);
    send("R6 -0",         64'h8000000000000000, 1'b0, 32'h00000000, 4'b0000);
  endtask

  task automatic t_denorm;
    send("R7 sub flush",  64'h0000000000000001, 1'b1, 32'h00000000, 4'b0001);
    send("R7 sub noflush",64'h8000000000000001, 1'b0, 32'h00000000, 4'b0010);
    send("R7 2.5 flush",  64'h4004000000000000, 1'b1, 32'h00000002, 4'b0010);
    send("R7 1.0 flush",  64'h3FF0000000000000, 1'b1, 32'h00000001, 4'b1000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_data = 64'h3FF0000000000000; flush_den = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_data = 64'h4004000000000000;
    chk("R10 first valid", 64'(out_valid), 64'd1);
    chk("R10 first result", 64'(out_result), 64'd1);
    chk("R10 blocked ready", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk("R10 held valid", 64'(out_valid), 64'd1);
    chk("R10 held result", 64'(out_result), 64'd1);
    chk("R10 held exact", 64'(out_exact), 64'd1);
    out_ready = 1'b1;
    #1;
    chk("R10 ready on drain", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 replaced result", 64'(out_result), 64'd2);
    chk("R10 replaced flags",
        64'({out_exact, out_invalid, out_inexact, out_denorm}), 64'b0010);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_trunc();
    t_range();
    t_special();
    t_zero();
    t_denorm();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule